// File: doc/BRIEF.md
# Write-Protection Unlock Detector

This block sits behind the bus demultiplexer of a byte-wide non-volatile memory. It sees each captured write as a one-cycle strobe that carries a 15-bit address and a data byte. The memory array is guarded as a whole: a write reaches it only after the host has issued a fixed three-write unlock sequence. The detector holds the three command writes back from the array. Once the sequence is complete, it passes each following write on as one cycle of a forward strobe. The array side then takes these writes as a single byte or as a page.

The host has to keep its writes close together. The write controller supplies a timing tick. If `WIN_TICKS` ticks pass with no write while a sequence is under way or the array is open, the detector drops back to the locked state. In the open state this marks the moment the internal programming cycle starts, and the next batch of writes needs a fresh unlock sequence. A write whose address or data does not fit the expected step also sends the detector back to the start.

Top module: `wp_unlock_detector`

## Requirements
- R1: During and directly after reset, `unlocked` and `fwd_wr` are both 0.
- R2: The three writes (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), given as (address, data) and in that order, raise `unlocked` in the cycle after the third write.
- R3: None of the three command writes produces a pulse on `fwd_wr`.
- R4: While `unlocked` is 1, every write gives exactly one `fwd_wr` pulse in the following cycle, and `unlocked` stays 1.
- R5: A write that does not match the expected step returns the detector to expecting the first step. That write is not taken as a first step, and it is not forwarded.
- R6: While the detector is locked, writes never produce a pulse on `fwd_wr`.
- R7: When `WIN_TICKS` cycles with `win_tick`=1 and no write occur after the last write, with a sequence under way or the array open, the detector returns to locked. `unlocked` falls in the cycle after the last of those ticks.
- R8: A write restarts the window count, including a write that arrives in the same cycle as a tick. Fewer than `WIN_TICKS` ticks between writes keep the progress made.
- R9: Both address and data must match a step: the right data at a wrong address fails, and so does the right address with wrong data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe for a captured write |
| wr_addr | input | 15 | Address of the captured write |
| wr_data | input | 8 | Data byte of the captured write |
| win_tick | input | 1 | Timing tick for the byte-load window |
| unlocked | output | 1 | The array accepts writes |
| fwd_wr | output | 1 | Forward the write of the previous cycle to the array |

## Verification
The directed sequences probe each step separately. A correct sequence is set against one with a wrong address, one with wrong data and one with a repeated first step, which shows whether the detector checks both fields and whether it restarts correctly. Idle gaps of `WIN_TICKS`-1 and of `WIN_TICKS` ticks, and a tick that coincides with a write, pin the window boundary down to one tick. Random traffic, biased toward the next correct step, mixes partial sequences, open periods and timeouts so that the transitions occur in many orders.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;

    localparam int WP_NSTEP = 3;

    // Expected address and data of each unlock step, in sequence order
    localparam logic [14:0] WP_STEP_ADDR [WP_NSTEP] = '{15'h5555, 15'h2AAA, 15'h5555};
    localparam logic [7:0]  WP_STEP_DATA [WP_NSTEP] = '{8'hAA, 8'h55, 8'hA0};

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_SEEN1  = 2'd1,
        ST_SEEN2  = 2'd2,
        ST_OPEN   = 2'd3
    } wp_state_e;

    typedef struct packed {
        wp_state_e state;
        logic      fwd;
        logic      unl;
    } wp_regs_t;

endpackage

// File: rtl/wp_step_match.sv
module wp_step_match
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output logic [WP_NSTEP-1:0] hit
);

    for (genvar k = 0; k < WP_NSTEP; k++) begin : g_step
        assign hit[k] = (addr == ADDR_W'(WP_STEP_ADDR[k])) &&
                        (data == DATA_W'(WP_STEP_DATA[k]));
    end

endmodule

// File: rtl/wp_window_timer.sv
module wp_window_timer #(
    parameter int WIN_TICKS = 4,
    localparam int CNT_W    = $clog2(WIN_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic restart,
    input  logic tick,
    output logic expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!arm || restart) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == CNT_W'(WIN_TICKS - 1)) begin
                expire = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wp_unlock_detector.sv
module wp_unlock_detector
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int WIN_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_tick,
    output logic              unlocked,
    output logic              fwd_wr
);

    wp_regs_t r_d, r_q;
    logic [WP_NSTEP-1:0] hit;
    logic step_hit;
    logic expire;

    wp_step_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    wp_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (r_q.state != ST_LOCKED),
        .restart (wr_valid),
        .tick    (win_tick),
        .expire  (expire)
    );

    always_comb begin
        case (r_q.state)
            ST_LOCKED: step_hit = hit[0];
            ST_SEEN1:  step_hit = hit[1];
            ST_SEEN2:  step_hit = hit[2];
            default:   step_hit = 1'b0;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        r_d.fwd = 1'b0;
        if (wr_valid) begin
            case (r_q.state)
                ST_OPEN:   r_d.fwd   = 1'b1;
                ST_LOCKED: r_d.state = step_hit ? ST_SEEN1 : ST_LOCKED;
                ST_SEEN1:  r_d.state = step_hit ? ST_SEEN2 : ST_LOCKED;
                default:   r_d.state = step_hit ? ST_OPEN  : ST_LOCKED;
            endcase
        end else if (expire) begin
            r_d.state = ST_LOCKED;
        end
        r_d.unl = (r_d.state == ST_OPEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_LOCKED, fwd: 1'b0, unl: 1'b0};
        else        r_q <= r_d;
    end

    assign unlocked = r_q.unl;
    assign fwd_wr   = r_q.fwd;

endmodule

// File: rtl/wp_unlock_chk.sv
module wp_unlock_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              win_tick,
    input logic              unlocked,
    input logic              fwd_wr
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!unlocked && !fwd_wr));

    // R3 R6
    fwd_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr |-> $past(wr_valid && unlocked));

    // R2
    open_after_last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_valid && wr_addr == ADDR_W'(15'h5555)
                                  && wr_data == DATA_W'(8'hA0)));

    // R4
    open_write_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && wr_valid) |=> (fwd_wr && unlocked));

    // R7
    close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(win_tick && !wr_valid));

endmodule

bind wp_unlock_detector wp_unlock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .win_tick (win_tick),
    .unlocked (unlocked),
    .fwd_wr   (fwd_wr)
);

// File: tb/wp_unlock_detector_test.sv
module wp_unlock_detector_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        win_tick = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        unlocked, fwd_wr;

    int checks = 0;
    int fails  = 0;
    int mst    = 0;
    int mcnt   = 0;
    logic exp_fwd = 1'b0;

    always #2.5 clk = ~clk;

    wp_unlock_detector #(.WIN_TICKS(WIN)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .win_tick (win_tick),
        .unlocked (unlocked),
        .fwd_wr   (fwd_wr)
    );

    function automatic bit step_ok(int s, logic [14:0] a, logic [7:0] d);
        case (s)
            0:       return a == 15'h5555 && d == 8'hAA;
            1:       return a == 15'h2AAA && d == 8'h55;
            2:       return a == 15'h5555 && d == 8'hA0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge
    task automatic cyc(bit v, logic [14:0] a, logic [7:0] d, bit t, string tag);
        wr_valid = v;
        wr_addr  = a;
        wr_data  = d;
        win_tick = t;
        exp_fwd  = 1'b0;
        if (v) begin
            if (mst == 3)                exp_fwd = 1'b1;
            else if (step_ok(mst, a, d)) mst++;
            else                         mst = 0;
            mcnt = 0;
        end else if (t && mst != 0) begin
            if (mcnt == WIN - 1) begin
                mst  = 0;
                mcnt = 0;
            end else begin
                mcnt++;
            end
        end
        @(negedge clk);
        check(tag, "unlocked", unlocked, mst == 3);
        check(tag, "fwd_wr", fwd_wr, exp_fwd);
        wr_valid = 1'b0;
        win_tick = 1'b0;
    endtask

    task automatic unlock_seq(string tag);
        cyc(1, 15'h5555, 8'hAA, 0, tag);
        cyc(1, 15'h2AAA, 8'h55, 0, tag);
        cyc(1, 15'h5555, 8'hA0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "unlocked", unlocked, 1'b0);
        check("R1", "fwd_wr", fwd_wr, 1'b0);
        rst_n = 1'b1;
        cyc(0, '0, '0, 0, "R1");

        // R6: writes while locked are dropped
        cyc(1, 15'h1234, 8'h11, 0, "R6");
        cyc(1, 15'h5555, 8'hA0, 0, "R6");

        // R2 R3: full sequence, command writes not forwarded
        unlock_seq("R2_R3");
        // R4: open writes forwarded one cycle later
        cyc(1, 15'h0100, 8'h5A, 0, "R4");
        cyc(1, 15'h0101, 8'hC3, 0, "R4");
        cyc(0, '0, '0, 0, "R4");

        // R8: WIN-1 ticks keep it open, a write restarts the count
        for (int i = 0; i < WIN - 1; i++) cyc(0, '0, '0, 1, "R8");
        cyc(1, 15'h0102, 8'h01, 1, "R8");
        for (int i = 0; i < WIN - 1; i++) cyc(0, '0, '0, 1, "R8");
        // R7: the WIN-th tick closes it
        cyc(0, '0, '0, 1, "R7");
        cyc(1, 15'h0103, 8'h02, 0, "R7");

        // R7: timeout during a partial sequence
        cyc(1, 15'h5555, 8'hAA, 0, "R7");
        for (int i = 0; i < WIN; i++) cyc(0, '0, '0, 1, "R7");
        cyc(1, 15'h2AAA, 8'h55, 0, "R7");
        cyc(1, 15'h5555, 8'hA0, 0, "R7");

        // R9: right data, wrong address; right address, wrong data
        cyc(1, 15'h5555, 8'hAA, 0, "R9");
        cyc(1, 15'h1AAA, 8'h55, 0, "R9");
        cyc(1, 15'h2AAA, 8'h55, 0, "R9");
        cyc(1, 15'h5555, 8'hAA, 0, "R9");
        cyc(1, 15'h2AAA, 8'h56, 0, "R9");

        // R5: repeated first step is a miss and does not restart
        cyc(1, 15'h5555, 8'hAA, 0, "R5");
        cyc(1, 15'h5555, 8'hAA, 0, "R5");
        cyc(1, 15'h2AAA, 8'h55, 0, "R5");
        cyc(1, 15'h5555, 8'hA0, 0, "R5");

        unlock_seq("R2");
        for (int i = 0; i < WIN; i++) cyc(0, '0, '0, 1, "R7");

        // Random traffic biased toward the next correct step
        for (int n = 0; n < 4000; n++) begin
            int sel;
            bit v, t;
            logic [14:0] a;
            logic [7:0] d;
            sel = int'($urandom % 8);
            v   = ($urandom % 2) == 0;
            t   = ($urandom % 3) == 0;
            a   = 15'($urandom);
            d   = 8'($urandom);
            if (sel < 5 && mst < 3) begin
                case (mst)
                    0: begin a = 15'h5555; d = 8'hAA; end
                    1: begin a = 15'h2AAA; d = 8'h55; end
                    default: begin a = 15'h5555; d = 8'hA0; end
                endcase
            end else if (sel == 5) begin
                a = ($urandom % 2) ? 15'h5555 : 15'h2AAA;
            end
            cyc(v, a, d, t, "R2/R4/R5/R7/R8");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule